// File: doc/BRIEF.md
# Double-Buffered Frame Data Transfer

This block moves per-channel line data between a frame-oriented serial side and a set of CPU-facing registers. A free-running timer divides time into frames of `SLOTS` slots, each `SLOT_CYCLES` clocks long. At every frame boundary the block does three things. It emits a one-cycle frame strobe. It raises an interrupt flag. It moves data one stage along both pipelines.

On the transmit side, a value written by the CPU during one frame goes onto the line for the whole of the next frame. On the receive side, line data is captured at the end of its frame into a shadow stage. One boundary later it is copied into the CPU receive register. Together these give the fixed two-frame path, and the CPU gets a full frame period to service each boundary.

The block has four further behaviours:
- Channels can be switched off individually. A switched-off channel transmits the all-ones idle pattern.
- A loopback mode feeds the transmitted frame back into the receive shadow in place of the line input.
- The interrupt flag is cleared by writing one to it.
- All register access goes through a simple synchronous read/write port.

Top module: `frame_buffer_xfer`

## Requirements
- R1: After reset the block is in a defined idle state:
  - `irq` and `frame_strobe` are 0.
  - Every channel drives all ones on `line_tx_data`.
  - The control register reads 0.
  - Every TX register reads all ones.
  - Every RX register reads 0.
- R2: `frame_strobe` is a single-cycle pulse, repeated every `SLOTS*SLOT_CYCLES` clocks. `slot_idx` is 0 in the strobe cycle. It then increases by one every `SLOT_CYCLES` clocks.
- R3: The frame flag is set at every boundary, in the same cycle that `frame_strobe` rises. It is visible as `irq` and as bit 0 of the status register (address 1).
  - Writing 1 to bit 0 of the status register clears the flag.
  - Writing 0 to it leaves the flag unchanged.
  - A boundary set wins over a clear in the same cycle.
- R4: A value written to the TX register of enabled channel i (address 2+i) during frame k appears on `line_tx_data[i*CH_W +: CH_W]` from the strobe that starts frame k+1. It stays there for that whole frame. `line_tx_data` changes only in strobe cycles.
- R5: With loopback off, the value on `line_rx_data[i*CH_W +: CH_W]` during frame k is readable from the RX register of channel i (address 2+NUM_CH+i) throughout frame k+2.
- R6: A channel whose enable bit is 0 (control register bit i) transmits all ones, whatever its TX register holds. Writing its TX register does not change the line.
- R7: With loopback on (control register bit 8), the receive shadow loads the frame being transmitted, and `line_rx_data` is ignored. Data written during frame k is readable from the RX register during frame k+3.
- R8: Register reads return data in the cycle after `rd_en`.
  - The control and TX registers read back the last value written to them.
  - Addresses above 2+2*NUM_CH-1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | BUS_W | Write data |
| rd_data | output | BUS_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Frame interrupt flag |
| frame_strobe | output | 1 | One-cycle pulse at each frame boundary |
| slot_idx | output | SLOT_W | Current slot within the frame |
| line_rx_data | input | NUM_CH*CH_W | Line receive data, channel i in bits [i*CH_W +: CH_W] |
| line_tx_data | output | NUM_CH*CH_W | Line transmit data, channel i in bits [i*CH_W +: CH_W] |

## Verification
The bench builds the block with three channels of eight bits, four slots of eight clocks each, a 16-bit bus and a 4-bit address. This gives a 32-cycle frame. That frame is short enough to run a table of eight consecutive frames through the pipeline. It is also long enough to read three RX registers, write three TX registers and acknowledge the flag inside one service window. With three channels, one channel can be disabled while its neighbours carry data in the same frame, so the idle pattern and the loopback path are checked side by side. The 4-bit address leaves unmapped addresses to probe.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

  // Control register bit that selects the internal loopback path.
  localparam int unsigned LOOP_BIT = 8;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned TX_BASE = 2;

  typedef enum logic [2:0] {
    RS_CTRL,
    RS_STAT,
    RS_TX,
    RS_RX,
    RS_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input int unsigned a, input int unsigned nch);
    if (a == 0) return RS_CTRL;
    if (a == STAT_ADDR) return RS_STAT;
    if (a >= TX_BASE && a < TX_BASE + nch) return RS_TX;
    if (a >= TX_BASE + nch && a < TX_BASE + 2 * nch) return RS_RX;
    return RS_NONE;
  endfunction

endpackage

// File: rtl/fbx_frame_timer.sv
module fbx_frame_timer #(
  parameter int unsigned SLOT_CYCLES = 8,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned SLOT_W = 2,
  localparam int unsigned CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              tick,
  output logic              strobe,
  output logic [SLOT_W-1:0] slot
);

  logic [CYC_W-1:0] cyc_q;
  logic             last_cyc;
  logic             last_slot;

  assign last_cyc  = (cyc_q == CYC_W'(SLOT_CYCLES - 1));
  assign last_slot = (slot == SLOT_W'(SLOTS - 1));
  assign tick      = last_cyc && last_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      slot   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= tick;
      if (last_cyc) begin
        cyc_q <= '0;
        slot  <= last_slot ? '0 : slot + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbx_chan_slice.sv
module fbx_chan_slice #(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            enable,
  input  logic            loopback,
  input  logic            tx_wr,
  input  logic [CH_W-1:0] wr_data,
  input  logic [CH_W-1:0] line_rx,
  output logic [CH_W-1:0] line_tx,
  output logic [CH_W-1:0] cpu_tx,
  output logic [CH_W-1:0] cpu_rx
);

  logic [CH_W-1:0] rx_shadow;

  // CPU-side transmit holding register: free to change at any time.
  always_ff @(posedge clk) begin
    if (rst) cpu_tx <= '1;
    else if (tx_wr) cpu_tx <= wr_data;
  end

  // Boundary transfers: one stage on transmit, two on receive.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_tx   <= '1;
      rx_shadow <= '0;
      cpu_rx    <= '0;
    end else if (tick) begin
      line_tx   <= enable ? cpu_tx : '1;
      rx_shadow <= loopback ? line_tx : line_rx;
      cpu_rx    <= rx_shadow;
    end
  end

endmodule

// File: rtl/fbx_reg_port.sv
module fbx_reg_port
  import fbx_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CH_W = 8,
  parameter int unsigned BUS_W = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LINE_W = NUM_CH * CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              tick,
  input  logic [LINE_W-1:0] tx_vals,
  input  logic [LINE_W-1:0] rx_vals,
  output logic [NUM_CH-1:0] ch_enable,
  output logic              loopback,
  output logic [NUM_CH-1:0] tx_wr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq
);

  reg_sel_e         sel;
  logic             flag_clr;
  logic [BUS_W-1:0] rd_next;

  assign sel      = decode_addr(int'(addr), NUM_CH);
  assign flag_clr = wr_en && (sel == RS_STAT) && wr_data[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_txwr
    assign tx_wr[g] = wr_en && (addr == ADDR_W'(TX_BASE + g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_enable <= '0;
      loopback  <= 1'b0;
    end else if (wr_en && sel == RS_CTRL) begin
      ch_enable <= wr_data[NUM_CH-1:0];
      loopback  <= wr_data[LOOP_BIT];
    end
  end

  // Boundary set takes priority over a concurrent acknowledge.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (tick) irq <= 1'b1;
    else if (flag_clr) irq <= 1'b0;
  end

  always_comb begin
    rd_next = '0;
    unique case (sel)
      RS_CTRL: begin
        rd_next[NUM_CH-1:0] = ch_enable;
        rd_next[LOOP_BIT]   = loopback;
      end
      RS_STAT: rd_next[0] = irq;
      RS_TX: begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr == ADDR_W'(TX_BASE + i)) rd_next[CH_W-1:0] = tx_vals[i*CH_W +: CH_W];
      end
      RS_RX: begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr == ADDR_W'(TX_BASE + NUM_CH + i)) rd_next[CH_W-1:0] = rx_vals[i*CH_W +: CH_W];
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/frame_buffer_xfer.sv
module frame_buffer_xfer #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CH_W = 8,
  parameter int unsigned BUS_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SLOT_CYCLES = 8,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned LINE_W = NUM_CH * CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq,
  output logic              frame_strobe,
  output logic [SLOT_W-1:0] slot_idx,
  input  logic [LINE_W-1:0] line_rx_data,
  output logic [LINE_W-1:0] line_tx_data
);

  logic              tick;
  logic [NUM_CH-1:0] ch_enable;
  logic              loopback;
  logic [NUM_CH-1:0] tx_wr;
  logic [LINE_W-1:0] tx_vals;
  logic [LINE_W-1:0] rx_vals;

  fbx_frame_timer #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .SLOTS      (SLOTS),
    .SLOT_W     (SLOT_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .strobe(frame_strobe),
    .slot  (slot_idx)
  );

  fbx_reg_port #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .tick     (tick),
    .tx_vals  (tx_vals),
    .rx_vals  (rx_vals),
    .ch_enable(ch_enable),
    .loopback (loopback),
    .tx_wr    (tx_wr),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fbx_chan_slice #(
      .CH_W(CH_W)
    ) u_slice (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .enable  (ch_enable[g]),
      .loopback(loopback),
      .tx_wr   (tx_wr[g]),
      .wr_data (wr_data[CH_W-1:0]),
      .line_rx (line_rx_data[g*CH_W +: CH_W]),
      .line_tx (line_tx_data[g*CH_W +: CH_W]),
      .cpu_tx  (tx_vals[g*CH_W +: CH_W]),
      .cpu_rx  (rx_vals[g*CH_W +: CH_W])
    );
  end

endmodule

// File: rtl/fbx_checker.sv
module fbx_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BUS_W = 16,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned LINE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wr_data,
  input logic              irq,
  input logic              frame_strobe,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [LINE_W-1:0] line_tx_data
);

  logic ack;
  assign ack = wr_en && (addr == ADDR_W'(1)) && wr_data[0];

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> !frame_strobe); // R2
  AST_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> (slot_idx == '0)); // R2
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot_idx) |-> (slot_idx == '0 || slot_idx == SLOT_W'($past(slot_idx) + 1'b1))); // R2
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> irq); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq); // R3
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ack |=> (!irq || frame_strobe)); // R3
  AST_LINE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe |-> $stable(line_tx_data)); // R4

endmodule

bind frame_buffer_xfer fbx_checker #(
  .ADDR_W(ADDR_W),
  .BUS_W (BUS_W),
  .SLOT_W(SLOT_W),
  .LINE_W(LINE_W)
) u_fbx_checker (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .addr        (addr),
  .wr_data     (wr_data),
  .irq         (irq),
  .frame_strobe(frame_strobe),
  .slot_idx    (slot_idx),
  .line_tx_data(line_tx_data)
);

// File: tb/test_frame_buffer_xfer.sv
module test_frame_buffer_xfer;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int CH_W = 8;
  localparam int BUS_W = 16;
  localparam int ADDR_W = 4;
  localparam int SLOT_CYCLES = 8;
  localparam int SLOTS = 4;
  localparam int SLOT_W = 2;
  localparam int LINE_W = NUM_CH * CH_W;
  localparam int FRAME = SLOT_CYCLES * SLOTS;
  localparam int RX_BASE = 2 + NUM_CH;
  localparam int NV = 8;

  // Per-frame CPU transmit words and line receive words (channel i at bits i*8).
  localparam logic [LINE_W-1:0] TXV [NV] = '{
    24'h030201, 24'hA1B2C3, 24'h00FF00, 24'h7E7E7E,
    24'h123456, 24'hFEDCBA, 24'h55AA55, 24'h0F0F0F};
  localparam logic [LINE_W-1:0] RXV [NV] = '{
    24'h111111, 24'h2468AC, 24'hDEAD01, 24'h00C0DE,
    24'h987654, 24'h010203, 24'hC3C3C3, 24'h5A6B7C};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BUS_W-1:0]  wr_data = '0;
  logic [BUS_W-1:0]  rd_data;
  logic              irq;
  logic              frame_strobe;
  logic [SLOT_W-1:0] slot_idx;
  logic [LINE_W-1:0] line_rx_data = '0;
  logic [LINE_W-1:0] line_tx_data;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_buffer_xfer #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .SLOT_CYCLES(SLOT_CYCLES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
  ) i_frame_buffer_xfer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .frame_strobe(frame_strobe), .slot_idx(slot_idx),
    .line_rx_data(line_rx_data), .line_tx_data(line_tx_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [BUS_W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (frame_strobe !== 1'b1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [BUS_W-1:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(irq === 1'b0 && frame_strobe === 1'b0, "R1 irq/strobe", {irq, frame_strobe}, 0);
    check(line_tx_data === '1, "R1 line idle", line_tx_data, 24'hFFFFFF);
    reg_rd(0, d);
    check(d === '0, "R1 ctrl", d, 0);
    reg_rd(2, d);
    check(d === 16'h00FF, "R1 tx reg", d, 16'h00FF);
    reg_rd(RX_BASE, d);
    check(d === '0, "R1 rx reg", d, 0);

    // Enable all channels, then walk the frame table (R4, R5).
    reg_wr(0, 16'h0007);
    for (int k = 0; k < NV; k++) begin
      wait_strobe();
      check(irq === 1'b1, "R3 flag set", irq, 1);
      if (k >= 1)
        check(line_tx_data === TXV[k-1], "R4 line tx", line_tx_data, TXV[k-1]);
      if (k >= 2)
        for (int c = 0; c < NUM_CH; c++) begin
          reg_rd(RX_BASE + c, d);
          check(d[CH_W-1:0] === RXV[k-2][c*CH_W +: CH_W], "R5 rx reg", d, RXV[k-2][c*CH_W +: CH_W]);
        end
      for (int c = 0; c < NUM_CH; c++)
        reg_wr(2 + c, {8'h00, TXV[k][c*CH_W +: CH_W]});
      line_rx_data = RXV[k];
      reg_wr(1, 16'h0001);
      check(irq === 1'b0, "R3 flag cleared", irq, 0);
    end

    // R8: readback of TX register and unmapped address
    reg_rd(3, d);
    check(d === {8'h00, TXV[NV-1][15:8]}, "R8 tx readback", d, {8'h00, TXV[NV-1][15:8]});
    reg_rd(15, d);
    check(d === '0, "R8 unmapped", d, 0);

    // R2: frame spacing and slot stepping
    wait_strobe();
    check(slot_idx === '0, "R2 slot at strobe", slot_idx, 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == SLOT_CYCLES) check(slot_idx === 2'd1, "R2 slot step", slot_idx, 1);
    end while (frame_strobe !== 1'b1);
    check(n == FRAME, "R2 frame period", n, FRAME);

    // R3: writing 0 leaves flag, status bit 0 shows it
    reg_wr(1, 16'h0000);
    reg_rd(1, d);
    check(d === 16'h0001 && irq === 1'b1, "R3 write zero ignored", d, 1);

    // R6/R7: loopback on, channel 1 disabled
    reg_wr(0, 16'h0105);
    reg_wr(2, 16'h0011);
    reg_wr(3, 16'h0022);
    reg_wr(4, 16'h0033);
    line_rx_data = 24'hA5A5A5;
    reg_rd(0, d);
    check(d === 16'h0105, "R8 ctrl readback", d, 16'h0105);
    wait_strobe();
    check(line_tx_data === 24'h33FF11, "R6 disabled idle", line_tx_data, 24'h33FF11);
    reg_wr(3, 16'h0077);
    wait_strobe();
    check(line_tx_data[15:8] === 8'hFF, "R6 write no effect", line_tx_data[15:8], 8'hFF);
    wait_strobe();
    reg_rd(RX_BASE, d);
    check(d === 16'h0011, "R7 loopback ch0", d, 16'h0011);
    reg_rd(RX_BASE + 1, d);
    check(d === 16'h00FF, "R7 loopback ch1", d, 16'h00FF);
    reg_rd(RX_BASE + 2, d);
    check(d === 16'h0033, "R7 loopback ch2", d, 16'h0033);

    finish_run();
  end

endmodule